// File: doc/BRIEF.md
# ECG Beat Extremum Detector

This block examines one heartbeat at a time, as a fixed window of unsigned converter samples. An unsigned sample cannot be positive or negative by itself. The block therefore subtracts a DC baseline from every sample and judges polarity from the signed result. For the window it reports the largest upward excursion, which covers the P, R and T waves, and the largest downward excursion, which covers the Q and S waves. Each excursion comes with the position of its sample inside the window.

A controller pulses `beat_start` at the start of each heartbeat. That pulse also captures the baseline for the whole window. Samples then arrive on a valid/ready stream:

- A sample is taken on a clock edge where both `s_valid` and `s_ready` are high.
- `s_ready` is high only while a window is open and `beat_start` is low.
- While `s_ready` is low the producer must hold its sample. Any value shown at that time is ignored.

Once the last sample of the window has been taken, `s_ready` falls and stays low until the next `beat_start`. At the same time a one-cycle `done` pulse announces the new results. The results then stay unchanged until the next `done`.

Top module: `ecg_beat_extremum`

## Requirements
- R1: After reset `done` and `s_ready` are low and all four result outputs read zero.
- R2: `s_ready` is high exactly when a window is open and `beat_start` is low. A window opens on the edge after `beat_start` is sampled high. While `s_ready` is low, `s_valid` and `s_sample` have no effect.
- R3: Each accepted sample is compared as the signed value `sample - baseline`, one bit wider than the sample. The baseline is captured on the edge where `beat_start` is high. A change on `baseline` while a window is open has no effect on that window.
- R4: `max_val` is the largest signed difference in the window. `max_idx` is the position of that sample, counted from 0 in order of acceptance (0 to WIN_LEN-1).
- R5: `min_val` is the smallest signed difference in the window. `min_idx` is the position of that sample, counted the same way as in R4.
- R6: When several samples share the extreme value, the earliest of them is reported. If every difference in a window is equal, both indices read 0.
- R7: `done` is high for exactly one cycle, in the cycle after the edge that accepts the WIN_LEN-th sample (WIN_LEN = 160 by default). The window is closed in that same cycle, so `s_ready` is low.
- R8: The four result outputs change only in a cycle where `done` is high. Between two `done` pulses they hold their values.
- R9: A `beat_start` inside an open window restarts it. The position counter returns to 0, both running extremes are cleared, and the baseline is captured again. Samples from the abandoned window do not affect the next results.
- R10: Cycles in which `s_valid` is low do not advance the position counter and do not change the running extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_start | input | 1 | Opens or restarts a window and captures the baseline |
| baseline | input | SAMPLE_W | DC reference, unsigned |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_sample | input | SAMPLE_W | Unsigned ECG sample |
| done | output | 1 | One-cycle pulse when new results are available |
| max_val | output | SAMPLE_W+1 | Largest signed difference, two's complement |
| max_idx | output | clog2(WIN_LEN) | Position of the largest difference |
| min_val | output | SAMPLE_W+1 | Smallest signed difference, two's complement |
| min_idx | output | clog2(WIN_LEN) | Position of the smallest difference |

## Verification
The hardest cases to reach from the ports involve the final sample of a window. That sample has to be folded into the published result in the same edge that closes the window, and a restart can abandon a window part of the way through. The stimulus covers both. It places extremes on the very first and very last positions, and it uses samples at the full-scale limits against a baseline at either rail. It also inserts `beat_start` in the middle of a window carrying out-of-range samples, and it drives `s_valid` high with extreme values while the window is closed. Irregular valid gaps and a baseline change in mid-window test that the position counter and the captured baseline ignore everything except accepted samples.

// File: rtl/ecg_ext_pkg.sv
package ecg_ext_pkg;

  // Which extreme a tracker follows.
  typedef enum logic {
    EXT_MAX = 1'b0,
    EXT_MIN = 1'b1
  } ext_kind_e;

  // Width of the signed difference for a given sample width.
  function automatic int diff_width(input int sample_w);
    return sample_w + 1;
  endfunction

  // Width of a position counter covering win_len entries.
  function automatic int idx_width(input int win_len);
    return (win_len <= 2) ? 1 : $clog2(win_len);
  endfunction

endpackage

// File: rtl/ecg_ext_window.sv
// Window sequencing: open/close, position counter, stream handshake, done.
module ecg_ext_window #(
  parameter int WIN_LEN = 160,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_start,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             accept,
  output logic             last,
  output logic [IDX_W-1:0] pos,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(WIN_LEN - 1);

  logic             open_q;
  logic [IDX_W-1:0] pos_q;
  logic             done_q;

  assign s_ready = open_q & ~beat_start;
  assign accept  = s_ready & s_valid;
  assign last    = accept & (pos_q == LAST_POS);
  assign pos     = pos_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (beat_start) begin
        open_q <= 1'b1;
        pos_q  <= '0;
      end else if (accept) begin
        if (last) begin
          open_q <= 1'b0;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);                                               // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);                                              // R7

  AST_CLOSED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !s_ready);                                             // R7

  AST_STALL_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_start && !accept) |=> $stable(pos_q));                     // R10

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_start |=> (s_ready || beat_start));                          // R2

  AST_START_ZEROES_POS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_start |=> (pos_q == '0));                                    // R9

endmodule

// File: rtl/ecg_ext_offset.sv
// Baseline capture and signed difference of each sample.
module ecg_ext_offset #(
  parameter int SAMPLE_W = 12,
  parameter int DIFF_W   = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [SAMPLE_W-1:0]      baseline_i,
  input  logic [SAMPLE_W-1:0]      sample_i,
  output logic signed [DIFF_W-1:0] diff_o
);

  logic [SAMPLE_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (capture) begin
      base_q <= baseline_i;
    end
  end

  always_comb begin
    diff_o = $signed({1'b0, sample_i}) - $signed({1'b0, base_q});
  end

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(base_q));                                    // R3

  AST_BASE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (base_q == $past(baseline_i)));                       // R3

endmodule

// File: rtl/ecg_ext_tracker.sv
// Running extreme for one polarity, plus the published copy.
module ecg_ext_tracker
  import ecg_ext_pkg::*;
#(
  parameter ext_kind_e KIND   = EXT_MAX,
  parameter int        DIFF_W = 13,
  parameter int        IDX_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     accept,
  input  logic                     last,
  input  logic signed [DIFF_W-1:0] diff,
  input  logic [IDX_W-1:0]         pos,
  output logic signed [DIFF_W-1:0] pub_val,
  output logic [IDX_W-1:0]         pub_idx
);

  localparam logic signed [DIFF_W-1:0] MOST_NEG = $signed({1'b1, {(DIFF_W-1){1'b0}}});
  localparam logic signed [DIFF_W-1:0] MOST_POS = $signed({1'b0, {(DIFF_W-1){1'b1}}});
  localparam logic signed [DIFF_W-1:0] SEED     = (KIND == EXT_MAX) ? MOST_NEG : MOST_POS;

  logic signed [DIFF_W-1:0] run_val;
  logic [IDX_W-1:0]         run_idx;
  logic                     better;
  logic signed [DIFF_W-1:0] next_val;
  logic [IDX_W-1:0]         next_idx;

  // Strict comparison keeps the earlier position on a tie.
  generate
    if (KIND == EXT_MAX) begin : g_max
      assign better = (diff > run_val);
    end else begin : g_min
      assign better = (diff < run_val);
    end
  endgenerate

  always_comb begin
    next_val = better ? diff : run_val;
    next_idx = better ? pos  : run_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_val <= SEED;
      run_idx <= '0;
      pub_val <= '0;
      pub_idx <= '0;
    end else begin
      if (clear) begin
        run_val <= SEED;
        run_idx <= '0;
      end else if (accept) begin
        run_val <= next_val;
        run_idx <= next_idx;
        if (last) begin
          pub_val <= next_val;
          pub_idx <= next_idx;
        end
      end
    end
  end

  generate
    if (KIND == EXT_MAX) begin : g_amax
      AST_RUN_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !last) |=> (run_val >= $past(run_val)));           // R4
    end else begin : g_amin
      AST_RUN_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !last) |=> (run_val <= $past(run_val)));           // R5
    end
  endgenerate

  AST_IDLE_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !accept) |=> ($stable(run_val) && $stable(run_idx))); // R10

endmodule

// File: rtl/ecg_beat_extremum.sv
// Top: per-window largest and smallest baseline-relative excursion.
module ecg_beat_extremum
  import ecg_ext_pkg::*;
#(
  parameter  int SAMPLE_W = 12,
  parameter  int WIN_LEN  = 160,
  localparam int DIFF_W   = SAMPLE_W + 1,
  localparam int IDX_W    = (WIN_LEN <= 2) ? 1 : $clog2(WIN_LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat_start,
  input  logic [SAMPLE_W-1:0]      baseline,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [SAMPLE_W-1:0]      s_sample,
  output logic                     done,
  output logic signed [DIFF_W-1:0] max_val,
  output logic [IDX_W-1:0]         max_idx,
  output logic signed [DIFF_W-1:0] min_val,
  output logic [IDX_W-1:0]         min_idx
);

  localparam int N_KIND = 2;

  logic                     accept;
  logic                     last;
  logic [IDX_W-1:0]         pos;
  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] ext_val [N_KIND];
  logic [IDX_W-1:0]         ext_idx [N_KIND];

  ecg_ext_window #(
    .WIN_LEN (WIN_LEN),
    .IDX_W   (IDX_W)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_start (beat_start),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .accept     (accept),
    .last       (last),
    .pos        (pos),
    .done       (done)
  );

  ecg_ext_offset #(
    .SAMPLE_W (SAMPLE_W),
    .DIFF_W   (DIFF_W)
  ) u_offset (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (beat_start),
    .baseline_i (baseline),
    .sample_i   (s_sample),
    .diff_o     (diff)
  );

  generate
    for (genvar k = 0; k < N_KIND; k++) begin : g_track
      ecg_ext_tracker #(
        .KIND   ((k == 0) ? EXT_MAX : EXT_MIN),
        .DIFF_W (DIFF_W),
        .IDX_W  (IDX_W)
      ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (beat_start),
        .accept  (accept),
        .last    (last),
        .diff    (diff),
        .pos     (pos),
        .pub_val (ext_val[k]),
        .pub_idx (ext_idx[k])
      );
    end
  endgenerate

  assign max_val = ext_val[0];
  assign max_idx = ext_idx[0];
  assign min_val = ext_val[1];
  assign min_idx = ext_idx[1];

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(max_val) && $stable(max_idx) &&
               $stable(min_val) && $stable(min_idx)));                // R8

  AST_MAX_NOT_BELOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (max_val >= min_val));                                   // R4

  AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((max_idx < IDX_W'(WIN_LEN)) && (min_idx < IDX_W'(WIN_LEN)))); // R5

endmodule

// File: tb/ecg_beat_extremum_tb.sv
module ecg_beat_extremum_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW  = 12;
  localparam int WL  = 160;
  localparam int DW  = SW + 1;
  localparam int IW  = 8;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          beat_start = 1'b0;
  logic [SW-1:0] baseline = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [SW-1:0] s_sample = '0;
  logic          done;
  logic signed [DW-1:0] max_val;
  logic [IW-1:0] max_idx;
  logic signed [DW-1:0] min_val;
  logic [IW-1:0] min_idx;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference model state
  int  m_open = 0, m_pos = 0, m_base = 0;
  int  m_rmax = 0, m_rmaxi = 0, m_rmin = 0, m_rmini = 0;
  int  m_pmax = 0, m_pmaxi = 0, m_pmin = 0, m_pmini = 0;
  int  m_done = 0;

  ecg_beat_extremum #(.SAMPLE_W(SW), .WIN_LEN(WL)) u_dut (
    .clk (clk), .rst_n (rst_n), .beat_start (beat_start), .baseline (baseline),
    .s_valid (s_valid), .s_ready (s_ready), .s_sample (s_sample), .done (done),
    .max_val (max_val), .max_idx (max_idx), .min_val (min_val), .min_idx (min_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference, advanced on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_pos = 0; m_base = 0; m_done = 0;
      m_rmax = -4096; m_rmaxi = 0; m_rmin = 4095; m_rmini = 0;
      m_pmax = 0; m_pmaxi = 0; m_pmin = 0; m_pmini = 0;
    end else begin
      int d;
      m_done = 0;
      if (beat_start) begin
        m_open = 1; m_pos = 0; m_base = int'(baseline);
        m_rmax = -4096; m_rmaxi = 0; m_rmin = 4095; m_rmini = 0;
      end else if (m_open == 1 && s_valid) begin
        d = int'(s_sample) - m_base;
        if (d > m_rmax) begin m_rmax = d; m_rmaxi = m_pos; end
        if (d < m_rmin) begin m_rmin = d; m_rmini = m_pos; end
        if (m_pos == WL - 1) begin
          m_pmax = m_rmax; m_pmaxi = m_rmaxi; m_pmin = m_rmin; m_pmini = m_rmini;
          m_done = 1; m_open = 0; m_pos = 0;
        end else begin
          m_pos = m_pos + 1;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R7", "done", int'(done), m_done);
    check("R2", "s_ready", int'(s_ready), (m_open == 1 && !beat_start) ? 1 : 0);
    check("R4", "max_val", int'(max_val), m_pmax);
    check("R4", "max_idx", int'(max_idx), m_pmaxi);
    check("R5", "min_val", int'(min_val), m_pmin);
    check("R5", "min_idx", int'(min_idx), m_pmini);
  endtask

  // Negative edge: compare, then the caller drives new inputs.
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  function automatic int shape(input int mode, input int i, input int b);
    int v;
    v = b;
    case (mode)
      0: begin
        if (i >= 20 && i < 30) v = b + 200;
        else if (i == 50) v = b - 300;
        else if (i >= 52 && i <= 54) v = b + 1500;
        else if (i == 56) v = b - 400;
        else if (i >= 100 && i < 120) v = b + 350;
      end
      2: begin
        if (i == 77) v = 4095;
        else if (i == 3) v = 0;
        else v = 2000;
      end
      3: begin
        if (i == 0) v = b - 50;
        else if (i == WL - 1) v = b + 60;
      end
      default: v = b;
    endcase
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  // Runs one window; gaps inserts idle cycles, bl_change alters the
  // baseline pin after that position, abort_at restarts mid-window.
  task automatic run_beat(input int mode, input int bl, input int sbase, input bit gaps,
                          input int bl_change, input int abort_at);
    int lfsr;
    lfsr = 16'hACE1;
    step();
    beat_start = 1'b1; baseline = SW'(bl); s_valid = 1'b0;
    step();
    beat_start = 1'b0;
    for (int i = 0; i < WL; i++) begin
      if (abort_at >= 0 && i == abort_at) return;
      if (gaps) begin
        lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
        if ((lfsr & 3) == 0) begin
          step();
          s_valid = 1'b0; s_sample = 12'hFFF;
        end
      end
      step();
      s_valid = 1'b1; s_sample = SW'(shape(mode, i, sbase));
      if (bl_change >= 0 && i == bl_change) baseline = 12'd0;
    end
    step();
    s_valid = 1'b0;
  endtask

  task automatic expect_result(input string req, input int mx, input int mxi, input int mn, input int mni);
    check(req, "done at window end", int'(done), 1);
    check(req, "max_val", int'(max_val), mx);
    check(req, "max_idx", int'(max_idx), mxi);
    check(req, "min_val", int'(min_val), mn);
    check(req, "min_idx", int'(min_idx), mni);
  endtask

  // Closed window: drive extreme samples with valid high, results must hold.
  task automatic idle_flood(input string req, input int mx, input int mxi, input int mn, input int mni);
    for (int k = 0; k < 4; k++) begin
      step();
      s_valid = 1'b1; s_sample = (k % 2 == 0) ? 12'hFFF : 12'h000;
    end
    step();
    s_valid = 1'b0;
    check(req, "s_ready while closed", int'(s_ready), 0);
    check(req, "held max_val", int'(max_val), mx);
    check(req, "held max_idx", int'(max_idx), mxi);
    check(req, "held min_val", int'(min_val), mn);
    check(req, "held min_idx", int'(min_idx), mni);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "done", int'(done), 0);
    check("R1", "s_ready", int'(s_ready), 0);
    check("R1", "max_val", int'(max_val), 0);
    check("R1", "max_idx", int'(max_idx), 0);
    check("R1", "min_val", int'(min_val), 0);
    check("R1", "min_idx", int'(min_idx), 0);
    rst_n = 1'b1;
    step();

    // R4 R5 R6: synthetic beat, R peak held for three samples
    run_beat(0, 2000, 2000, 1'b0, -1, -1);
    expect_result("R4", 1500, 52, -400, 56);
    idle_flood("R8", 1500, 52, -400, 56);

    // R10: same beat with idle gaps
    run_beat(0, 1800, 1800, 1'b1, -1, -1);
    expect_result("R10", 1500, 52, -400, 56);

    // R6: flat window
    run_beat(1, 1234, 1234, 1'b0, -1, -1);
    expect_result("R6", 0, 0, 0, 0);

    // R3: baseline pin changes mid-window
    run_beat(0, 2000, 2000, 1'b1, 10, -1);
    expect_result("R3", 1500, 52, -400, 56);

    // R9: abandoned window with wild samples, then restart
    run_beat(2, 0, 0, 1'b0, -1, 90);
    check("R8", "no done on abort", int'(done), 0);
    check("R8", "old max kept", int'(max_val), 1500);
    run_beat(0, 2100, 2100, 1'b0, -1, -1);
    expect_result("R9", 1500, 52, -400, 56);

    // full-scale limits against rail baselines
    run_beat(2, 0, 0, 1'b0, -1, -1);
    expect_result("R4", 4095, 77, 0, 3);
    run_beat(2, 4095, 0, 1'b1, -1, -1);
    expect_result("R5", 0, 77, -4095, 3);
    run_beat(2, 2048, 0, 1'b0, -1, -1);
    expect_result("R5", 2047, 77, -2048, 3);

    // extremes on first and last positions
    run_beat(3, 1000, 1000, 1'b0, -1, -1);
    expect_result("R7", 60, WL - 1, -50, 0);
    step();
    check("R7", "done one cycle", int'(done), 0);

    repeat (3) step();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule